// File: doc/BRIEF.md
# Direct-Mapped Address Translation Cache with ASID Tags

This block caches recent Sv32 page translations so that a load, store or fetch does not need a page walk each time. Every slot holds one mapping from a virtual page number to a physical page number. Each slot also holds the address-space identifier it belongs to, the eight permission and status bits of its page table entry, and a flag that marks a 4 MiB megapage. The low bits of the virtual page number pick the slot. The remaining bits are kept as a tag and compared on lookup.

A lookup presents a virtual address, the current ASID and a translate-enable flag. One cycle later the block answers with hit or miss, the physical address and the stored flag bits. When translation is off, the answer is a bypass: the physical address equals the virtual address and the slots are left alone. After a walk, the refill port writes a slot. The flush port handles the four fence forms in one cycle: by page and ASID, by page only, by ASID only, and everything.

Top module: `tlb_dm`

## Requirements
- R1: When `lk_xlate_en` is 0, the response has `rsp_bypass`=1, `rsp_hit`=0, `rsp_flags`=0 and `rsp_paddr` equal to `lk_vaddr` zero-extended to 34 bits. No slot is read or changed by it.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle with `lk_valid`=1. After reset `rsp_valid` and `rsp_hit` are 0.
- R3: After reset every slot is empty, so the first translated lookup of any page misses. A miss returns `rsp_paddr`=0 and `rsp_flags`=0.
- R4: A translated lookup hits when the slot at index `vaddr[15:12]` is valid, its tag matches, and either its ASID equals `lk_asid` or its global bit (flag bit 5) is 1. A hit on a 4 KiB page returns `{ppn, vaddr[11:0]}` and the stored flags.
- R5: A non-global slot whose tag matches but whose ASID differs from `lk_asid` gives a miss.
- R6: A slot refilled with `rf_mega`=1 compares only VPN bits 19..10 (vaddr[31:22]) within its tag. A hit returns `{ppn[21:10], vaddr[21:0]}`.
- R7: A refill always writes the slot at index `rf_vpn[3:0]`. Any earlier mapping there is evicted.
- R8: A flush with both page and ASID selected clears only a valid slot that matches the page, has that ASID and is not global.
- R9: A flush with only the page selected clears a matching slot whatever its ASID or global bit.
- R10: A flush with only the ASID selected clears every non-global slot with that ASID. Global slots and other ASIDs stay.
- R11: A flush with neither selector clears every slot.
- R12: A refill in the same cycle as any flush is dropped.
- R13: A lookup in the same cycle as a refill or flush sees the slot contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 9 | Current address-space identifier |
| lk_xlate_en | input | 1 | 1 = translate, 0 = bypass |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Translation found |
| rsp_bypass | output | 1 | Answer is an untranslated bypass |
| rsp_paddr | output | 34 | Physical address |
| rsp_flags | output | 8 | Stored PTE bits (0 V, 1 R, 2 W, 3 X, 4 U, 5 G, 6 A, 7 D) |
| rf_valid | input | 1 | Refill write |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_asid | input | 9 | Refill ASID |
| rf_ppn | input | 22 | Refill physical page number |
| rf_flags | input | 8 | Refill PTE bits |
| rf_mega | input | 1 | Refill is a megapage |
| fl_valid | input | 1 | Flush request |
| fl_use_va | input | 1 | Flush selects by page |
| fl_use_asid | input | 1 | Flush selects by ASID |
| fl_vpn | input | 20 | Flush virtual page number |
| fl_asid | input | 9 | Flush ASID |

## Verification
The hardest cases to reach from the ports need one exact slot history: a global and a non-global slot that share an ASID, a megapage slot probed with an address whose middle VPN bits differ, or a refill and a flush in the same cycle as a lookup of that slot. Random traffic seldom lines these up. A directed prologue therefore builds each history on purpose and probes it. Random traffic then draws VPNs from a small pool and ASIDs from three values, so that hits, ASID misses, evictions and every flush form occur often and are checked against a bench model of the slots.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 34;
  localparam int OFS_W  = 12;
  localparam int VPN_W  = 20;
  localparam int VPN0_W = 10;
  localparam int PPN_W  = 22;
  localparam int ASID_W = 9;
  localparam int FLAG_W = 8;
  localparam int FLG_G  = 5;
endpackage

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp #(
  parameter int TAG_W = 16,
  parameter int IGN_W = 6
) (
  input  logic [TAG_W-1:0] stored_tag,
  input  logic             stored_mega,
  input  logic [TAG_W-1:0] query_tag,
  output logic             eq
);
  logic [TAG_W-1:0] cmp_mask;

  always_comb begin
    cmp_mask = stored_mega ? ({TAG_W{1'b1}} << IGN_W) : {TAG_W{1'b1}};
    eq       = ((stored_tag ^ query_tag) & cmp_mask) == '0;
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [TAG_W-1:0]                 wr_tag,
  input  logic [ASID_W-1:0]                wr_asid,
  input  logic [PPN_W-1:0]                 wr_ppn,
  input  logic [FLAG_W-1:0]                wr_flags,
  input  logic                             wr_mega,
  input  logic [ENTRIES-1:0]               clr_vec,
  input  logic [IDX_W-1:0]                 rd_idx,
  output logic                             rd_valid,
  output logic [TAG_W-1:0]                 rd_tag,
  output logic [ASID_W-1:0]                rd_asid,
  output logic [PPN_W-1:0]                 rd_ppn,
  output logic [FLAG_W-1:0]                rd_flags,
  output logic                             rd_mega,
  output logic [ENTRIES-1:0]               all_valid,
  output logic [ENTRIES-1:0][TAG_W-1:0]    all_tag,
  output logic [ENTRIES-1:0][ASID_W-1:0]   all_asid,
  output logic [ENTRIES-1:0]               all_mega,
  output logic [ENTRIES-1:0]               all_glob
);
  logic [ENTRIES-1:0]             valid_q, valid_d;
  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [ENTRIES-1:0][FLAG_W-1:0] flags_q;
  logic [ENTRIES-1:0]             mega_q;

  // next-state of the valid bits: flush clears, refill sets
  always_comb begin
    valid_d = valid_q & ~clr_vec;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // payload: no reset, written only on a refill to that slot
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        tag_q[i]   <= wr_tag;
        asid_q[i]  <= wr_asid;
        ppn_q[i]   <= wr_ppn;
        flags_q[i] <= wr_flags;
        mega_q[i]  <= wr_mega;
      end
    end
    assign all_glob[i] = flags_q[i][FLG_G];
  end

  assign rd_valid  = valid_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_asid   = asid_q[rd_idx];
  assign rd_ppn    = ppn_q[rd_idx];
  assign rd_flags  = flags_q[rd_idx];
  assign rd_mega   = mega_q[rd_idx];
  assign all_valid = valid_q;
  assign all_tag   = tag_q;
  assign all_asid  = asid_q;
  assign all_mega  = mega_q;

  // R7: a refill leaves its slot valid in the next cycle
  assert_refill_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)]);

  // R3: reset leaves no valid slot
  assert_reset_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> valid_q == '0);
endmodule

// File: rtl/tlb_flush_sel.sv
module tlb_flush_sel
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 16,
  parameter int IGN_W   = 6
) (
  input  logic                           fl_valid,
  input  logic                           fl_use_va,
  input  logic                           fl_use_asid,
  input  logic [IDX_W-1:0]               fl_idx,
  input  logic [TAG_W-1:0]               fl_tag,
  input  logic [ASID_W-1:0]              fl_asid,
  input  logic [ENTRIES-1:0]             all_valid,
  input  logic [ENTRIES-1:0][TAG_W-1:0]  all_tag,
  input  logic [ENTRIES-1:0][ASID_W-1:0] all_asid,
  input  logic [ENTRIES-1:0]             all_mega,
  input  logic [ENTRIES-1:0]             all_glob,
  output logic [ENTRIES-1:0]             clr_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_sel
    logic tag_eq, page_hit, asid_hit;
    tlb_tag_cmp #(.TAG_W(TAG_W), .IGN_W(IGN_W)) u_cmp (
      .stored_tag (all_tag[i]),
      .stored_mega(all_mega[i]),
      .query_tag  (fl_tag),
      .eq         (tag_eq)
    );
    always_comb begin
      page_hit   = (fl_idx == IDX_W'(i)) && tag_eq;
      asid_hit   = (all_asid[i] == fl_asid) && !all_glob[i];
      clr_vec[i] = fl_valid && all_valid[i]
                 && (!fl_use_va   || page_hit)
                 && (!fl_use_asid || asid_hit);
    end
  end

  // R10: an ASID-selected flush never touches a global slot
  always_comb begin
    if (fl_valid && fl_use_asid)
      assert_asid_spares_global_R10: assert ((clr_vec & all_glob) == '0);
  end
endmodule

// File: rtl/tlb_lookup_pipe.sv
module tlb_lookup_pipe
  import tlb_pkg::*;
#(
  parameter int TAG_W = 16,
  parameter int IGN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_xlate_en,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [ASID_W-1:0] rd_asid,
  input  logic [PPN_W-1:0]  rd_ppn,
  input  logic [FLAG_W-1:0] rd_flags,
  input  logic              rd_mega,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_bypass,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [FLAG_W-1:0] rsp_flags
);
  localparam int SUPER_OFS = OFS_W + VPN0_W;

  logic              tag_eq, hit_d, byp_d;
  logic [PA_W-1:0]   paddr_d;
  logic [FLAG_W-1:0] flags_d;

  tlb_tag_cmp #(.TAG_W(TAG_W), .IGN_W(IGN_W)) u_cmp (
    .stored_tag (rd_tag),
    .stored_mega(rd_mega),
    .query_tag  (lk_vaddr[VA_W-1 -: TAG_W]),
    .eq         (tag_eq)
  );

  always_comb begin
    byp_d   = !lk_xlate_en;
    hit_d   = lk_xlate_en && rd_valid && tag_eq
           && (rd_flags[FLG_G] || (rd_asid == lk_asid));
    paddr_d = '0;
    flags_d = '0;
    if (byp_d) begin
      paddr_d = PA_W'(lk_vaddr);
    end else if (hit_d) begin
      flags_d = rd_flags;
      if (rd_mega) paddr_d = {rd_ppn[PPN_W-1:VPN0_W], lk_vaddr[SUPER_OFS-1:0]};
      else         paddr_d = {rd_ppn, lk_vaddr[OFS_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_bypass <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit    <= hit_d;
        rsp_bypass <= byp_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (lk_valid) begin
      rsp_paddr <= paddr_d;
      rsp_flags <= flags_d;
    end
  end

  // R2: one-cycle answer latency
  assert_answer_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_no_spurious_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  // R1: bypass answers carry the untranslated address and never hit
  assert_bypass_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_xlate_en) |=> (rsp_bypass && !rsp_hit
                                   && rsp_paddr == PA_W'($past(lk_vaddr))));

  // R5: a hit needs an ASID match or a global slot
  assert_hit_asid_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_xlate_en && rd_valid && !rd_flags[FLG_G] && rd_asid != lk_asid)
      |=> !rsp_hit);
endmodule

// File: rtl/tlb_dm.sv
module tlb_dm
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [31:0]       lk_vaddr,
  input  logic [8:0]        lk_asid,
  input  logic              lk_xlate_en,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_bypass,
  output logic [33:0]       rsp_paddr,
  output logic [7:0]        rsp_flags,
  input  logic              rf_valid,
  input  logic [19:0]       rf_vpn,
  input  logic [8:0]        rf_asid,
  input  logic [21:0]       rf_ppn,
  input  logic [7:0]        rf_flags,
  input  logic              rf_mega,
  input  logic              fl_valid,
  input  logic              fl_use_va,
  input  logic              fl_use_asid,
  input  logic [19:0]       fl_vpn,
  input  logic [8:0]        fl_asid
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int IGN_W = VPN0_W - IDX_W;

  logic                           wr_en;
  logic [ENTRIES-1:0]             clr_vec;
  logic                           rd_valid, rd_mega;
  logic [TAG_W-1:0]               rd_tag;
  logic [ASID_W-1:0]              rd_asid;
  logic [PPN_W-1:0]               rd_ppn;
  logic [FLAG_W-1:0]              rd_flags;
  logic [ENTRIES-1:0]             all_valid, all_mega, all_glob;
  logic [ENTRIES-1:0][TAG_W-1:0]  all_tag;
  logic [ENTRIES-1:0][ASID_W-1:0] all_asid;

  // a flush wins over a refill in the same cycle
  assign wr_en = rf_valid && !fl_valid;

  tlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (rf_vpn[IDX_W-1:0]),
    .wr_tag   (rf_vpn[VPN_W-1 -: TAG_W]),
    .wr_asid  (rf_asid),
    .wr_ppn   (rf_ppn),
    .wr_flags (rf_flags),
    .wr_mega  (rf_mega),
    .clr_vec  (clr_vec),
    .rd_idx   (lk_vaddr[OFS_W +: IDX_W]),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_asid  (rd_asid),
    .rd_ppn   (rd_ppn),
    .rd_flags (rd_flags),
    .rd_mega  (rd_mega),
    .all_valid(all_valid),
    .all_tag  (all_tag),
    .all_asid (all_asid),
    .all_mega (all_mega),
    .all_glob (all_glob)
  );

  tlb_flush_sel #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .IGN_W(IGN_W)) u_flush (
    .fl_valid   (fl_valid),
    .fl_use_va  (fl_use_va),
    .fl_use_asid(fl_use_asid),
    .fl_idx     (fl_vpn[IDX_W-1:0]),
    .fl_tag     (fl_vpn[VPN_W-1 -: TAG_W]),
    .fl_asid    (fl_asid),
    .all_valid  (all_valid),
    .all_tag    (all_tag),
    .all_asid   (all_asid),
    .all_mega   (all_mega),
    .all_glob   (all_glob),
    .clr_vec    (clr_vec)
  );

  tlb_lookup_pipe #(.TAG_W(TAG_W), .IGN_W(IGN_W)) u_lookup (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_vaddr   (lk_vaddr),
    .lk_asid    (lk_asid),
    .lk_xlate_en(lk_xlate_en),
    .rd_valid   (rd_valid),
    .rd_tag     (rd_tag),
    .rd_asid    (rd_asid),
    .rd_ppn     (rd_ppn),
    .rd_flags   (rd_flags),
    .rd_mega    (rd_mega),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_bypass (rsp_bypass),
    .rsp_paddr  (rsp_paddr),
    .rsp_flags  (rsp_flags)
  );

  // R11 and R12: a full flush empties the array even with a refill beside it
  assert_flush_all_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !fl_use_va && !fl_use_asid) |=> all_valid == '0);

  // R12: a refill beside any flush does not set its slot when the slot was empty
  assert_flush_beats_refill_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && rf_valid && !all_valid[rf_vpn[IDX_W-1:0]])
      |=> !all_valid[$past(rf_vpn[IDX_W-1:0])]);
endmodule

// File: tb/tlb_dm_test.sv
module tlb_dm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 0, lk_xlate_en = 0;
  logic [31:0] lk_vaddr = '0;
  logic [8:0]  lk_asid = '0;
  logic        rsp_valid, rsp_hit, rsp_bypass;
  logic [33:0] rsp_paddr;
  logic [7:0]  rsp_flags;
  logic        rf_valid = 0, rf_mega = 0;
  logic [19:0] rf_vpn = '0;
  logic [8:0]  rf_asid = '0;
  logic [21:0] rf_ppn = '0;
  logic [7:0]  rf_flags = '0;
  logic        fl_valid = 0, fl_use_va = 0, fl_use_asid = 0;
  logic [19:0] fl_vpn = '0;
  logic [8:0]  fl_asid = '0;

  always #2.5 clk = ~clk;

  tlb_dm uut (.*);

  // requested operation for the next cycle
  logic        n_lk = 0, n_en = 0, n_rf = 0, n_rmega = 0, n_fl = 0, n_fva = 0, n_fas = 0;
  logic [31:0] n_va = '0;
  logic [8:0]  n_asid = '0, n_rasid = '0, n_fasid = '0;
  logic [19:0] n_rvpn = '0, n_fvpn = '0;
  logic [21:0] n_rppn = '0;
  logic [7:0]  n_rflags = '0;
  string       n_tag = "R4";

  // bench model of the slots
  logic        m_v [16];
  logic [19:0] m_vpn [16];
  logic [8:0]  m_as [16];
  logic [21:0] m_ppn [16];
  logic [7:0]  m_fl [16];
  logic        m_mg [16];

  int checks = 0, fails = 0;
  logic        pend = 0, e_hit = 0, e_byp = 0;
  logic [33:0] e_pa = '0;
  logic [7:0]  e_fl = '0;
  string       e_tag = "";

  function automatic logic page_match(input int i, input logic [19:0] vpn);
    if (m_mg[i]) return m_vpn[i][19:10] == vpn[19:10] && i == int'(vpn[3:0]);
    return m_vpn[i] == vpn;
  endfunction

  task automatic check_pending();
    if (!pend) return;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_hit !== e_hit || rsp_bypass !== e_byp
        || rsp_paddr !== e_pa || rsp_flags !== e_fl) begin
      fails++;
      $display("FAIL %s: got v=%b hit=%b byp=%b pa=%h fl=%h, expected v=1 hit=%b byp=%b pa=%h fl=%h",
               e_tag, rsp_valid, rsp_hit, rsp_bypass, rsp_paddr, rsp_flags,
               e_hit, e_byp, e_pa, e_fl);
    end
  endtask

  task automatic tick();
    int ix;
    @(negedge clk);
    check_pending();
    if (!pend && !n_lk) begin
      // R2: no answer without a request
      checks++;
      if (rsp_valid !== 1'b0) begin
        fails++;
        $display("FAIL R2: rsp_valid=%b expected 0", rsp_valid);
      end
    end
    lk_valid = n_lk; lk_vaddr = n_va; lk_asid = n_asid; lk_xlate_en = n_en;
    rf_valid = n_rf; rf_vpn = n_rvpn; rf_asid = n_rasid; rf_ppn = n_rppn;
    rf_flags = n_rflags; rf_mega = n_rmega;
    fl_valid = n_fl; fl_use_va = n_fva; fl_use_asid = n_fas; fl_vpn = n_fvpn; fl_asid = n_fasid;
    // expectation from the contents before this cycle's update (R13)
    pend = n_lk; e_tag = n_tag; e_hit = 0; e_byp = 0; e_pa = '0; e_fl = '0;
    if (n_lk) begin
      ix = int'(n_va[15:12]);
      if (!n_en) begin
        e_byp = 1; e_pa = {2'b00, n_va};
      end else if (m_v[ix] && page_match(ix, n_va[31:12]) && (m_fl[ix][5] || m_as[ix] == n_asid)) begin
        e_hit = 1; e_fl = m_fl[ix];
        e_pa = m_mg[ix] ? {m_ppn[ix][21:10], n_va[21:0]} : {m_ppn[ix], n_va[11:0]};
      end
    end
    if (n_fl) begin
      for (int i = 0; i < 16; i++) begin
        logic pg, as;
        pg = (i == int'(n_fvpn[3:0])) && page_match(i, n_fvpn);
        as = (m_as[i] == n_fasid) && !m_fl[i][5];
        if ((!n_fva || pg) && (!n_fas || as)) m_v[i] = 0;
      end
    end else if (n_rf) begin
      ix = int'(n_rvpn[3:0]);
      m_v[ix] = 1; m_vpn[ix] = n_rvpn; m_as[ix] = n_rasid;
      m_ppn[ix] = n_rppn; m_fl[ix] = n_rflags; m_mg[ix] = n_rmega;
    end
    n_lk = 0; n_rf = 0; n_fl = 0; n_tag = "R4";
  endtask

  task automatic lookup(input logic [31:0] va, input logic [8:0] asid, input logic en, input string tag);
    n_lk = 1; n_va = va; n_asid = asid; n_en = en; n_tag = tag;
  endtask
  task automatic refill(input logic [31:0] va, input logic [8:0] asid, input logic [21:0] ppn,
                        input logic [7:0] flg, input logic mg);
    n_rf = 1; n_rvpn = va[31:12]; n_rasid = asid; n_rppn = ppn; n_rflags = flg; n_rmega = mg;
  endtask
  task automatic flush(input logic uva, input logic uas, input logic [31:0] va, input logic [8:0] asid);
    n_fl = 1; n_fva = uva; n_fas = uas; n_fvpn = va[31:12]; n_fasid = asid;
  endtask

  localparam logic [7:0] FL_N = 8'h43;  // V R A
  localparam logic [7:0] FL_G = 8'h63;  // V R G A
  localparam logic [31:0] VA_A = 32'h1000_2abc, VA_B = 32'h2000_2def, VA_C = 32'h3000_2111;
  localparam logic [31:0] VA_E1 = 32'h0005_5000, VA_E2 = 32'h0006_6004;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2: watchdog expired, actual cycles 100000 expected fewer");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < 16; i++) m_v[i] = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    checks++;
    if (rsp_valid !== 0 || rsp_hit !== 0) begin
      fails++;
      $display("FAIL R2: after reset v=%b hit=%b expected 0 0", rsp_valid, rsp_hit);
    end
    // R1 bypass
    lookup(32'h1234_5678, 9'd1, 0, "R1"); tick();
    // R3 compulsory miss
    lookup(VA_A, 9'd1, 1, "R3"); tick();
    refill(VA_A, 9'd1, 22'h2AAAA, FL_N, 0); tick();
    lookup(VA_A, 9'd1, 1, "R4"); tick();
    lookup(VA_A, 9'd2, 1, "R5"); tick();
    // R7 eviction
    refill(VA_B, 9'd1, 22'h1BBBB, FL_N, 0); tick();
    lookup(VA_A, 9'd1, 1, "R7"); tick();
    lookup(VA_B, 9'd1, 1, "R7"); tick();
    // R13 lookup beside a refill and a flush
    lookup(VA_B, 9'd1, 1, "R13"); refill(VA_C, 9'd1, 22'h0CCCC, FL_N, 0); tick();
    lookup(VA_C, 9'd1, 1, "R13"); flush(0, 0, 0, 0); tick();
    lookup(VA_C, 9'd1, 1, "R11"); tick();
    // R6 megapage
    refill(32'h4050_3000, 9'd1, 22'h3F5A5, FL_N, 1); tick();
    lookup(32'h407F_3456, 9'd1, 1, "R6"); tick();
    lookup(32'h4090_3456, 9'd1, 1, "R6"); tick();
    // R8 page + ASID
    refill(VA_E1, 9'd1, 22'h00111, FL_N, 0); tick();
    refill(VA_E2, 9'd1, 22'h00222, FL_G, 0); tick();
    lookup(VA_E2, 9'd7, 1, "R4"); flush(1, 1, VA_E1, 9'd2); tick();
    lookup(VA_E1, 9'd1, 1, "R8"); flush(1, 1, VA_E2, 9'd1); tick();
    lookup(VA_E2, 9'd1, 1, "R8"); flush(1, 1, VA_E1, 9'd1); tick();
    lookup(VA_E1, 9'd1, 1, "R8"); tick();
    // R9 page only clears a global slot
    flush(1, 0, VA_E2, 9'd0); tick();
    lookup(VA_E2, 9'd1, 1, "R9"); tick();
    // R10 ASID only
    refill(32'h0000_7000, 9'd3, 22'h00777, FL_N, 0); tick();
    refill(32'h0000_8000, 9'd3, 22'h00888, FL_G, 0); tick();
    refill(32'h0000_9000, 9'd4, 22'h00999, FL_N, 0); tick();
    flush(0, 1, 0, 9'd3); tick();
    lookup(32'h0000_7000, 9'd3, 1, "R10"); tick();
    lookup(32'h0000_8000, 9'd1, 1, "R10"); tick();
    lookup(32'h0000_9000, 9'd4, 1, "R10"); tick();
    // R12 flush beats a refill
    refill(32'h0000_A000, 9'd4, 22'h00AAA, FL_N, 0); flush(0, 1, 0, 9'd5); tick();
    lookup(32'h0000_A000, 9'd4, 1, "R12"); tick();
    // random traffic
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] va;
      int r;
      va = {$urandom_range(0, 3) == 0 ? 12'h000 : 12'h001, 4'($urandom_range(0, 15)), 16'($urandom)};
      va[31:22] = 10'($urandom_range(0, 2));
      r = $urandom_range(0, 99);
      if (r < 60) lookup(va, 9'($urandom_range(1, 3)), $urandom_range(0, 9) != 0,
                         "R4");
      if (r >= 40 && r < 85)
        refill(va ^ 32'(($urandom_range(0, 1)) << 18), 9'($urandom_range(1, 3)), 22'($urandom),
               ($urandom_range(0, 4) == 0) ? FL_G : FL_N, $urandom_range(0, 5) == 0);
      if (r >= 80 && r < 90)
        flush($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, va, 9'($urandom_range(1, 3)));
      tick();
    end
    tick(); tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule